// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Programmer

This block keeps the two threshold offsets that a FIFO's flag logic compares against: one for the almost-empty flag and one for the almost-full flag. The two values are independent, so each flag can be placed anywhere in the memory. The write-clock side loads them in one of two ways. The first is bit-serial, through a one-bit input gated by a serial enable. The second is word-wide, from the data bus gated by the write enable. A shared load qualifier must be high for either path to act.

The read-clock side can present the stored offsets on the output bus, one per qualified edge. This works whichever path last wrote them. A master reset loads one of eight built-in offset pairs, chosen by two select pins and the load pin. A partial reset restarts every load and readback sequence and leaves the offsets as they are.

Top module: `flagOffsetProg`

## Requirements
- R1: While `masterRst` is high, each `wrClk` edge loads both offsets with the default chosen by index {loadEn, defSel[1], defSel[0]}. The defaults for indices 0 to 7 are 7, 15, 31, 63, 127, 255, 3 and 1, and both offsets get the same value. Each `rdClk` edge during master reset clears `dataOut` to 0.
- R2: Each `wrClk` edge with `loadEn` and `serEn` high (and `wrEn` low) stores `serIn` as one bit. The first 9 bits go to the almost-empty offset, bit 0 first, and the next 9 bits go to the almost-full offset, bit 0 first.
- R3: After 18 serial bits, further serial edges change nothing. A low `loadEn` restarts the serial sequence at bit 0 of the almost-empty offset.
- R4: Each `wrClk` edge with `loadEn` and `wrEn` high writes `dataIn` to one offset. The targets alternate, starting with almost-empty, so a third write goes to almost-empty again. Only one offset changes per edge.
- R5: A `wrClk` edge with `loadEn` low sends the next parallel write back to the almost-empty offset.
- R6: Each `rdClk` edge with `loadEn` and `rdEn` high registers one offset onto `dataOut`, visible after that edge. The order alternates: almost-empty first, then almost-full, then almost-empty again. A low `loadEn` at an `rdClk` edge restarts the order at almost-empty.
- R7: `partialRst` leaves both offsets unchanged and blocks all loads while it is high. It restarts the serial, parallel and readback sequences at their first step.
- R8: `wrEn` and `serEn` have no effect on the offsets while `loadEn` is low.
- R9: When `wrEn` and `serEn` are both high with `loadEn`, only the parallel write happens and the serial bit position does not advance.
- R10: `dataOut` keeps its value on every `rdClk` edge without `rdEn` and `loadEn` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Load-side clock |
| rdClk | input | 1 | Readback-side clock |
| masterRst | input | 1 | Synchronous master reset, active high; loads defaults |
| partialRst | input | 1 | Synchronous partial reset, active high; keeps offsets |
| loadEn | input | 1 | Load qualifier; also the third default-select bit during master reset |
| serEn | input | 1 | Serial load enable |
| serIn | input | 1 | Serial data bit |
| wrEn | input | 1 | Parallel load enable |
| dataIn | input | 9 | Parallel offset value |
| rdEn | input | 1 | Readback enable |
| defSel | input | 2 | Default pair select, sampled during master reset |
| dataOut | output | 9 | Offset readback |

## Verification
The assertions assume that both resets and every control input are synchronous to both clocks and change well away from either clock's rising edge. They also assume the offsets never change near an `rdClk` edge that reads them. The stimulus keeps to this in three ways. It drives every input from the falling edge of `wrClk`, with `rdClk` a fixed 1 ns behind `wrClk`. It always leaves an idle cycle with `loadEn` low between a load and a readback. It never reads while a reset is high.

// File: rtl/flagOffsetPkg.sv
`timescale 1ns/1ps
package flagOffsetPkg;
  localparam int OFF_W    = 9;
  localparam int N_OFF    = 2;
  localparam int SER_BITS = N_OFF * OFF_W;
  localparam int CNT_W    = $clog2(SER_BITS + 1);
  localparam int IDX_W    = 3;

  // load-side strobes from control to datapath
  typedef struct packed {
    logic             defLoad;
    logic [IDX_W-1:0] defIdx;
    logic [N_OFF-1:0] parWr;
    logic             serWrite;
    logic [CNT_W-1:0] serIdx;
  } wrStrobe_t;

  // readback-side strobes
  typedef struct packed {
    logic [N_OFF-1:0] cap;
  } rdStrobe_t;

  function automatic logic [OFF_W-1:0] defaultOffset(input logic [IDX_W-1:0] idx);
    logic [OFF_W-1:0] val;
    case (idx)
      3'd6:    val = OFF_W'(3);
      3'd7:    val = OFF_W'(1);
      default: val = OFF_W'((32'd1 << (int'(idx) + 3)) - 32'd1);
    endcase
    return val;
  endfunction
endpackage

// File: rtl/offsetCtrl.sv
`timescale 1ns/1ps
module offsetCtrl
  import flagOffsetPkg::*;
(
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             masterRst,
  input  logic             partialRst,
  input  logic             loadEn,
  input  logic             serEn,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       defSel,
  output wrStrobe_t        wrStb,
  output rdStrobe_t        rdStb,
  output logic [CNT_W-1:0] serCount
);
  localparam logic [CNT_W-1:0] SER_LAST = CNT_W'(SER_BITS);

  logic             seqClear;
  logic             parSel;
  logic             rdSel;
  logic             serOpen;
  logic             wrQual;
  logic             rdQual;

  assign seqClear = masterRst | partialRst | ~loadEn;
  assign serOpen  = (serCount != SER_LAST);
  assign wrQual   = ~masterRst & ~partialRst & loadEn;
  assign rdQual   = ~masterRst & ~partialRst & loadEn & rdEn;

  // load-side sequencing: serial bit position and parallel target toggle
  always_ff @(posedge wrClk) begin
    if (seqClear) begin
      serCount <= '0;
      parSel   <= 1'b0;
    end else if (wrEn) begin
      parSel   <= ~parSel;
    end else if (serEn && serOpen) begin
      serCount <= serCount + CNT_W'(1);
    end
  end

  // readback order toggle
  always_ff @(posedge rdClk) begin
    if (seqClear) rdSel <= 1'b0;
    else if (rdEn) rdSel <= ~rdSel;
  end

  always_comb begin
    wrStb          = '0;
    wrStb.defLoad  = masterRst;
    wrStb.defIdx   = {loadEn, defSel};
    wrStb.parWr[0] = wrQual & wrEn & ~parSel;
    wrStb.parWr[1] = wrQual & wrEn & parSel;
    wrStb.serWrite = wrQual & serEn & ~wrEn & serOpen;
    wrStb.serIdx   = serCount;
    rdStb.cap[0]   = rdQual & ~rdSel;
    rdStb.cap[1]   = rdQual & rdSel;
  end
endmodule

// File: rtl/offsetRegs.sv
`timescale 1ns/1ps
module offsetRegs
  import flagOffsetPkg::*;
(
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             masterRst,
  input  wrStrobe_t        wrStb,
  input  rdStrobe_t        rdStb,
  input  logic             serIn,
  input  logic [OFF_W-1:0] parIn,
  output logic [OFF_W-1:0] emptyOff,
  output logic [OFF_W-1:0] fullOff,
  output logic [OFF_W-1:0] dataOut
);
  for (genvar gi = 0; gi < N_OFF; gi++) begin : g_off
    logic [OFF_W-1:0] regQ;
    logic [OFF_W-1:0] regNext;

    always_comb begin
      regNext = regQ;
      if (wrStb.parWr[gi]) regNext = parIn;
      for (int b = 0; b < OFF_W; b++) begin
        if (wrStb.serWrite && (wrStb.serIdx == CNT_W'(gi * OFF_W + b)))
          regNext[b] = serIn;
      end
    end

    always_ff @(posedge wrClk) begin
      if (wrStb.defLoad) regQ <= defaultOffset(wrStb.defIdx);
      else               regQ <= regNext;
    end
  end

  assign emptyOff = g_off[0].regQ;
  assign fullOff  = g_off[1].regQ;

  always_ff @(posedge rdClk) begin
    if (masterRst)        dataOut <= '0;
    else if (rdStb.cap[0]) dataOut <= emptyOff;
    else if (rdStb.cap[1]) dataOut <= fullOff;
  end
endmodule

// File: rtl/flagOffsetProg.sv
`timescale 1ns/1ps
module flagOffsetProg
  import flagOffsetPkg::*;
(
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             masterRst,
  input  logic             partialRst,
  input  logic             loadEn,
  input  logic             serEn,
  input  logic             serIn,
  input  logic             wrEn,
  input  logic [OFF_W-1:0] dataIn,
  input  logic             rdEn,
  input  logic [1:0]       defSel,
  output logic [OFF_W-1:0] dataOut
);
  wrStrobe_t        wrStb;
  rdStrobe_t        rdStb;
  logic [CNT_W-1:0] serCount;
  logic [OFF_W-1:0] emptyOff;
  logic [OFF_W-1:0] fullOff;

  offsetCtrl u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .loadEn(loadEn), .serEn(serEn), .wrEn(wrEn), .rdEn(rdEn), .defSel(defSel),
    .wrStb(wrStb), .rdStb(rdStb), .serCount(serCount)
  );

  offsetRegs u_regs (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .wrStb(wrStb),
    .rdStb(rdStb), .serIn(serIn), .parIn(dataIn), .emptyOff(emptyOff),
    .fullOff(fullOff), .dataOut(dataOut)
  );
endmodule

// File: rtl/flagOffsetProg_chk.sv
`timescale 1ns/1ps
module flagOffsetProg_chk
  import flagOffsetPkg::*;
(
  input logic             wrClk,
  input logic             rdClk,
  input logic             masterRst,
  input logic             partialRst,
  input logic             loadEn,
  input logic             serEn,
  input logic             wrEn,
  input logic             rdEn,
  input logic [OFF_W-1:0] dataOut,
  input logic [OFF_W-1:0] emptyOff,
  input logic [OFF_W-1:0] fullOff,
  input logic [CNT_W-1:0] serCount
);
  // R3
  ser_saturate_chk: assert property (@(posedge wrClk) disable iff (masterRst)
    (loadEn && serEn && !wrEn && !partialRst && serCount == CNT_W'(SER_BITS))
      |=> ($stable(emptyOff) && $stable(fullOff)));

  // R4
  par_single_target_chk: assert property (@(posedge wrClk) disable iff (masterRst)
    (loadEn && wrEn) |=> ($stable(emptyOff) || $stable(fullOff)));

  // R7
  partial_keep_chk: assert property (@(posedge wrClk) disable iff (masterRst)
    partialRst |=> ($stable(emptyOff) && $stable(fullOff)));

  // R8
  no_load_hold_chk: assert property (@(posedge wrClk) disable iff (masterRst)
    !loadEn |=> ($stable(emptyOff) && $stable(fullOff)));

  // R6
  rd_source_chk: assert property (@(posedge rdClk) disable iff (masterRst)
    (rdEn && loadEn && !partialRst)
      |=> (dataOut == $past(emptyOff) || dataOut == $past(fullOff)));

  // R10
  rd_hold_chk: assert property (@(posedge rdClk) disable iff (masterRst)
    !(rdEn && loadEn) |=> $stable(dataOut));
endmodule

bind flagOffsetProg flagOffsetProg_chk u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
  .loadEn(loadEn), .serEn(serEn), .wrEn(wrEn), .rdEn(rdEn), .dataOut(dataOut),
  .emptyOff(emptyOff), .fullOff(fullOff), .serCount(serCount)
);

// File: tb/flagOffsetProg_tb.sv
`timescale 1ns/1ps
module flagOffsetProg_tb;
  logic       wrClk = 0, rdClk = 0;
  logic       masterRst = 1, partialRst = 0, loadEn = 0, serEn = 0, serIn = 0;
  logic       wrEn = 0, rdEn = 0;
  logic [8:0] dataIn = 0;
  logic [1:0] defSel = 0;
  logic [8:0] dataOut;

  int testsRun = 0, testsFailed = 0;
  bit done = 0;
  logic [8:0] modelE, modelF;
  logic [8:0] expQ[$];
  string      tagQ[$];
  int         defTab[8] = '{7, 15, 31, 63, 127, 255, 3, 1};

  flagOffsetProg u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .loadEn(loadEn), .serEn(serEn), .serIn(serIn), .wrEn(wrEn), .dataIn(dataIn),
    .rdEn(rdEn), .defSel(defSel), .dataOut(dataOut)
  );

  always #2.5 wrClk = ~wrClk;
  initial begin #1; forever #2.5 rdClk = ~rdClk; end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected value per qualified readback edge
  always @(posedge rdClk) begin
    if (!masterRst && !partialRst && rdEn && loadEn) begin
      #1;
      if (expQ.size() == 0) check(0, "R6 unexpected read", dataOut, 0);
      else begin
        logic [8:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(dataOut == e, t, dataOut, e);
      end
    end
  end

  task automatic step(); @(negedge wrClk); endtask

  task automatic doMaster(input int s);
    masterRst = 1; loadEn = s[2]; defSel = s[1:0];
    step(); step();
    check(dataOut == 0, "R1 reset clears dataOut", dataOut, 0);
    masterRst = 0; loadEn = 0; defSel = 0;
    modelE = 9'(defTab[s]); modelF = 9'(defTab[s]);
    step();
  endtask

  // driver: pushes expected readback values, then drives the reads
  task automatic readSeq(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      expQ.push_back((i % 2 == 0) ? modelE : modelF);
      tagQ.push_back(tag);
    end
    loadEn = 1; rdEn = 1;
    for (int i = 0; i < n; i++) step();
    loadEn = 0; rdEn = 0;
    step();
  endtask

  task automatic serialBits(input logic [17:0] bits, input int n);
    for (int i = 0; i < n; i++) begin serIn = bits[i]; step(); end
  endtask

  task automatic serialLoad(input logic [8:0] e, input logic [8:0] f, input int extra);
    loadEn = 1; serEn = 1;
    serialBits({f, e}, 18);
    serialBits(18'h3FFFF, extra);
    loadEn = 0; serEn = 0; serIn = 0;
    modelE = e; modelF = f;
    step();
  endtask

  task automatic parWrites(input logic [8:0] a, input logic [8:0] b, input logic [8:0] c, input int n);
    loadEn = 1; wrEn = 1;
    dataIn = a; step();
    if (n > 1) begin dataIn = b; step(); end
    if (n > 2) begin dataIn = c; step(); end
    loadEn = 0; wrEn = 0;
    step();
  endtask

  initial begin
    step();
    // R1: all eight default pairs
    for (int s = 0; s < 8; s++) begin
      doMaster(s);
      readSeq(2, "R1 default pair");
    end
    // R2: serial load, readback (R6 covers the order)
    serialLoad(9'h0A5, 9'h13C, 0);
    readSeq(2, "R2 serial load");
    // R3: extra bits ignored
    serialLoad(9'h1F0, 9'h00F, 6);
    readSeq(2, "R3 extra serial bits");
    // R3: interrupted load restarts at bit 0
    loadEn = 1; serEn = 1; serialBits(18'h2AAAA, 5);
    loadEn = 0; serEn = 0; step();
    serialLoad(9'h111, 9'h0EE, 0);
    readSeq(2, "R3 restart after load low");
    // R4: parallel pair, then a third write wraps to almost-empty
    parWrites(9'h055, 9'h1AA, 0, 2); modelE = 9'h055; modelF = 9'h1AA;
    readSeq(2, "R4 parallel pair");
    parWrites(9'h101, 9'h0C3, 9'h07E, 3); modelE = 9'h07E; modelF = 9'h0C3;
    readSeq(2, "R4 third write wraps");
    // R5: load low restarts the parallel order
    parWrites(9'h033, 0, 0, 1);
    parWrites(9'h044, 0, 0, 1); modelE = 9'h044;
    readSeq(2, "R5 parallel order restart");
    // R6: three reads wrap to almost-empty
    readSeq(3, "R6 readback order");
    // R10: output holds without a qualified read
    wrEn = 1; dataIn = 9'h1FF; rdEn = 1; step(); step();
    wrEn = 0; rdEn = 0; step();
    check(dataOut == modelE, "R10 dataOut held", dataOut, modelE);
    // R8: enables without load
    wrEn = 1; serEn = 1; serIn = 1; dataIn = 9'h16B;
    repeat (5) step();
    wrEn = 0; serEn = 0; serIn = 0; step();
    readSeq(2, "R8 no load no change");
    // R7: partial reset keeps offsets
    serialLoad(9'h0D2, 9'h129, 0);
    partialRst = 1; step(); step(); partialRst = 0; step();
    readSeq(2, "R7 offsets kept");
    // R7: partial reset mid-serial restarts at bit 0
    loadEn = 1; serEn = 1; serialBits(18'h3FFFF, 4);
    partialRst = 1; step(); partialRst = 0;
    serialBits({9'h08D, 9'h172}, 18);
    loadEn = 0; serEn = 0; serIn = 0; step();
    modelE = 9'h172; modelF = 9'h08D;
    readSeq(2, "R7 serial restart");
    // R7: partial reset mid-parallel restarts at almost-empty
    loadEn = 1; wrEn = 1; dataIn = 9'h011; step();
    wrEn = 0; partialRst = 1; step();
    partialRst = 0; wrEn = 1; dataIn = 9'h022; step();
    loadEn = 0; wrEn = 0; step();
    modelE = 9'h022;
    readSeq(2, "R7 parallel restart");
    // R9: both enables, parallel wins
    loadEn = 1; wrEn = 1; serEn = 1; serIn = 0; dataIn = 9'h0F1; step();
    loadEn = 0; wrEn = 0; serEn = 0; step();
    modelE = 9'h0F1;
    readSeq(2, "R9 parallel wins");
    // R9: serial position does not advance
    loadEn = 1; wrEn = 1; serEn = 1; serIn = 1; dataIn = 9'h1FF; step();
    wrEn = 0; serialBits({9'h0, 9'h06C}, 9);
    loadEn = 0; serEn = 0; serIn = 0; step();
    modelE = 9'h06C;
    readSeq(2, "R9 serial not advanced");
    step();
    check(expQ.size() == 0, "R6 all reads observed", expQ.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule